// File: doc/BRIEF.md
# Two-Level Breakpoint Trigger Unit

This block watches a processor's instruction-address bus and its operand address and data buses. It raises a debug trigger without stopping the core. Three comparators run side by side on every valid bus cycle:

- an instruction-address match, in which a mask picks the bits that count;
- an operand-address window with inclusive unsigned limits;
- an operand-data match with a per-bit mask.

A trigger-definition register picks the comparators for each level. It also selects one-level or two-level sequencing and holds a two-bit response code. That code goes out with the trigger pulse, so the system can choose what to do with the event.

The trigger is one-shot. After it fires, further matches are ignored until the trigger-definition register is written again. A small status code tracks progress through the sequence. This code can always be read on its own output. It is also placed on the shared debug nibble whenever that nibble is not carrying trace information. All configuration comes in through a write-only register port.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: The instruction-address comparator matches when `((pcAddr ^ pcValue) & pcMask) == 0`. A mask bit of 1 means that address bit is compared.
- R2: The window comparator matches when `rngLow <= opAddr <= rngHigh`, taken as unsigned values, with both limits inclusive. This holds even when the two limits are equal at the top of the address space.
- R3: The data comparator matches when `((opData ^ dataValue) & dataMask) == 0`. A mask bit of 1 means that data bit is compared.
- R4: Comparator results count only in cycles where `busValid` is high. A matching value with `busValid` low has no effect.
- R5: In one-level mode, a match on any comparator enabled for level 1 fires the trigger. `trigPulse` is high for exactly one cycle, in the cycle after the matching bus cycle. In that cycle `trigAction` equals the response field, and `trigAction` is 0 otherwise.
- R6: In two-level mode, a level-1 match arms level 2 and does not pulse. A later level-2 match fires the trigger. A level-2 match seen before arming is ignored. When a bus cycle holds both a level-1 and a level-2 match while waiting for level 1, it only arms.
- R7: The status codes are 0 = idle, 1 = waiting for level 1, 2 = level 1 hit, 3 = waiting for level 2, 4 = level 2 hit. Status moves only in this sequence. After a hit the unit is one-shot: no further pulse occurs until the trigger-definition register is rewritten.
- R8: Writing the trigger-definition register restarts the sequence. Status becomes 1 if any level-1 enable bit is set in the written value, and 0 if none is. Matches in the cycle of that write are ignored.
- R9: `ddataOut` shows `traceData` while `traceBusy` is high. Otherwise it shows the status code, zero-extended to 4 bits.
- R10: After reset the status is 0, `trigPulse` is low and no comparator is enabled. `statusOut` always shows the current status code.
- R11: Register selects on `cfgSel`:
  - 0 = pcValue
  - 1 = pcMask
  - 2 = rngLow
  - 3 = rngHigh
  - 4 = dataValue
  - 5 = dataMask
  - 6 = trigger definition

  Trigger-definition fields:
  - bits [1:0] = response code
  - bit [2] = two-level enable
  - bits [5:3] = level-1 enables for {data, window, pc}
  - bits [8:6] = level-2 enables in the same order

  Address and data registers take the low bits of `cfgData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Register select for the write |
| cfgData | input | CFG_W | Write data |
| busValid | input | 1 | Qualifies the monitored bus values this cycle |
| pcAddr | input | ADDR_W | Instruction address being executed |
| opAddr | input | ADDR_W | Operand address |
| opData | input | DATA_W | Operand data value |
| traceBusy | input | 1 | Debug nibble is carrying trace data this cycle |
| traceData | input | 4 | Trace nibble to forward while busy |
| trigPulse | output | 1 | One-cycle trigger indication |
| trigAction | output | 2 | Response code, valid with trigPulse |
| ddataOut | output | 4 | Shared debug nibble |
| statusOut | output | 4 | Current breakpoint status code |

## Verification
The bench builds the unit with ADDR_W and DATA_W set to 16, and CFG_W left at 32. With these widths the top of the address space (0xFFFF) is cheap to reach for the inclusive-limit window case. Short random operand and address values also collide often with randomly written compare values and masks. A behavioural model follows the status sequence, the pulse and the action code on every clock. Directed cases cover:

- a level-2 match seen before arming;
- a level-1 and a level-2 match in the same bus cycle;
- a trigger rewrite in the same cycle as a live match.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_L1 = 3'd1,
    ST_HIT_L1  = 3'd2,
    ST_WAIT_L2 = 3'd3,
    ST_HIT_L2  = 3'd4
  } bkptStatE;

  localparam logic [2:0] SEL_PC_VAL  = 3'd0;
  localparam logic [2:0] SEL_PC_MASK = 3'd1;
  localparam logic [2:0] SEL_RNG_LO  = 3'd2;
  localparam logic [2:0] SEL_RNG_HI  = 3'd3;
  localparam logic [2:0] SEL_DAT_VAL = 3'd4;
  localparam logic [2:0] SEL_DAT_MSK = 3'd5;
  localparam logic [2:0] SEL_TDEF    = 3'd6;

  localparam int NUM_CMP  = 3;
  localparam int CMP_PC   = 0;
  localparam int CMP_RNG  = 1;
  localparam int CMP_DAT  = 2;

  localparam int RESP_W   = 2;
  localparam int RESP_LSB = 0;
  localparam int TWO_BIT  = 2;
  localparam int L1_LSB   = 3;
  localparam int L2_LSB   = L1_LSB + NUM_CMP;

  // Strobes from datapath to control
  typedef struct packed {
    logic              tdefWrite;
    logic              newArm;
    logic              twoLevel;
    logic              l1Hit;
    logic              l2Hit;
    logic [RESP_W-1:0] resp;
  } ctrlStrobeT;

endpackage

// File: rtl/bkpt_datapath.sv
`timescale 1ns/1ps
module bkpt_datapath
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  output ctrlStrobeT        strb
);

  logic [ADDR_W-1:0]  pcVal, pcMask, rngLo, rngHi;
  logic [DATA_W-1:0]  datVal, datMask;
  logic [RESP_W-1:0]  respCode;
  logic               twoLevel;
  logic [NUM_CMP-1:0] l1En, l2En;
  logic [NUM_CMP-1:0] cmpHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcVal    <= '0;
      pcMask   <= '0;
      rngLo    <= '0;
      rngHi    <= '0;
      datVal   <= '0;
      datMask  <= '0;
      respCode <= '0;
      twoLevel <= 1'b0;
      l1En     <= '0;
      l2En     <= '0;
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_PC_VAL:  pcVal   <= cfgData[ADDR_W-1:0];
        SEL_PC_MASK: pcMask  <= cfgData[ADDR_W-1:0];
        SEL_RNG_LO:  rngLo   <= cfgData[ADDR_W-1:0];
        SEL_RNG_HI:  rngHi   <= cfgData[ADDR_W-1:0];
        SEL_DAT_VAL: datVal  <= cfgData[DATA_W-1:0];
        SEL_DAT_MSK: datMask <= cfgData[DATA_W-1:0];
        SEL_TDEF: begin
          respCode <= cfgData[RESP_LSB +: RESP_W];
          twoLevel <= cfgData[TWO_BIT];
          l1En     <= cfgData[L1_LSB +: NUM_CMP];
          l2En     <= cfgData[L2_LSB +: NUM_CMP];
        end
        default: ;
      endcase
    end
  end

  // One comparator per slot; the slot index picks the variant
  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    if (gi == CMP_PC) begin : g_pc
      assign cmpHit[gi] = ((pcAddr ^ pcVal) & pcMask) == '0;
    end else if (gi == CMP_RNG) begin : g_rng
      assign cmpHit[gi] = (opAddr >= rngLo) && (opAddr <= rngHi);
    end else begin : g_dat
      assign cmpHit[gi] = ((opData ^ datVal) & datMask) == '0;
    end
  end

  always_comb begin
    strb.tdefWrite = cfgWe && (cfgSel == SEL_TDEF);
    strb.newArm    = |cfgData[L1_LSB +: NUM_CMP];
    strb.twoLevel  = twoLevel;
    strb.l1Hit     = busValid && |(cmpHit & l1En);
    strb.l2Hit     = busValid && |(cmpHit & l2En);
    strb.resp      = respCode;
  end

  // R2
  range_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && l1En == 3'b010 && rngLo == rngHi && opAddr == rngHi) |-> strb.l1Hit);

endmodule

// File: rtl/bkpt_control.sv
`timescale 1ns/1ps
module bkpt_control
  import bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  output bkptStatE          status,
  output logic              trigPulse,
  output logic [RESP_W-1:0] trigAction
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status     <= ST_IDLE;
      trigPulse  <= 1'b0;
      trigAction <= '0;
    end else begin
      trigPulse  <= 1'b0;
      trigAction <= '0;
      if (strb.tdefWrite) begin
        status <= strb.newArm ? ST_WAIT_L1 : ST_IDLE;
      end else begin
        case (status)
          ST_WAIT_L1: if (strb.l1Hit) begin
            if (strb.twoLevel) begin
              status <= ST_WAIT_L2;
            end else begin
              status     <= ST_HIT_L1;
              trigPulse  <= 1'b1;
              trigAction <= strb.resp;
            end
          end
          ST_WAIT_L2: if (strb.l2Hit) begin
            status     <= ST_HIT_L2;
            trigPulse  <= 1'b1;
            trigAction <= strb.resp;
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R7
  pulse_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> (status == ST_HIT_L1 || status == ST_HIT_L2));

  // R6
  arm_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_HIT_L2 && $past(status) != ST_HIT_L2) |-> $past(status) == ST_WAIT_L2);

  // R8
  tdef_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.tdefWrite) |-> (!trigPulse && (status == ST_IDLE || status == ST_WAIT_L1)));

endmodule

// File: rtl/bkpt_trigger_unit.sv
`timescale 1ns/1ps
module bkpt_trigger_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic              traceBusy,
  input  logic [3:0]        traceData,
  output logic              trigPulse,
  output logic [1:0]        trigAction,
  output logic [3:0]        ddataOut,
  output logic [3:0]        statusOut
);

  ctrlStrobeT strb;
  bkptStatE   status;

  bkpt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) i_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .busValid(busValid), .pcAddr(pcAddr), .opAddr(opAddr), .opData(opData),
    .strb(strb)
  );

  bkpt_control i_ctl (
    .clk(clk), .rstN(rstN), .strb(strb), .status(status),
    .trigPulse(trigPulse), .trigAction(trigAction)
  );

  assign statusOut = {1'b0, status};
  assign ddataOut  = traceBusy ? traceData : statusOut;

  // R4
  pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(busValid));

endmodule

// File: tb/test_bkpt_trigger_unit.sv
`timescale 1ns/1ps
module test_bkpt_trigger_unit;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [2:0]    cfgSel = '0;
  logic [CW-1:0] cfgData = '0;
  logic          busValid = 1'b0;
  logic [AW-1:0] pcAddr = '0, opAddr = '0;
  logic [DW-1:0] opData = '0;
  logic          traceBusy = 1'b0;
  logic [3:0]    traceData = '0;
  logic          trigPulse;
  logic [1:0]    trigAction;
  logic [3:0]    ddataOut, statusOut;

  always #2.5 clk = ~clk;

  bkpt_trigger_unit #(.ADDR_W(AW), .DATA_W(DW), .CFG_W(CW)) i_bkpt_trigger_unit (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .busValid(busValid), .pcAddr(pcAddr), .opAddr(opAddr), .opData(opData),
    .traceBusy(traceBusy), .traceData(traceData), .trigPulse(trigPulse),
    .trigAction(trigAction), .ddataOut(ddataOut), .statusOut(statusOut)
  );

  int    checks = 0;
  int    fails = 0;
  int    pulseCnt = 0;
  int    lastAct = 0;
  string curReq = "R10";
  bit    started = 0;

  // Behavioural reference state
  logic [AW-1:0] mPcVal = '0, mPcMask = '0, mLo = '0, mHi = '0;
  logic [DW-1:0] mDv = '0, mDm = '0;
  int            mResp = 0, mSt = 0, mAct = 0;
  bit            mTwo = 0, mPulse = 0;
  bit [2:0]      mL1 = '0, mL2 = '0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : refModel
    bit pcM, rgM, dM, h1, h2;
    started = 1;
    if (!rstN) begin
      mPcVal = '0; mPcMask = '0; mLo = '0; mHi = '0; mDv = '0; mDm = '0;
      mResp = 0; mSt = 0; mAct = 0; mTwo = 0; mPulse = 0; mL1 = '0; mL2 = '0;
    end else begin
      mPulse = 0; mAct = 0;
      pcM = ((pcAddr ^ mPcVal) & mPcMask) == 0;
      rgM = (opAddr >= mLo) && (opAddr <= mHi);
      dM  = ((opData ^ mDv) & mDm) == 0;
      h1  = busValid && ((mL1[0] && pcM) || (mL1[1] && rgM) || (mL1[2] && dM));
      h2  = busValid && ((mL2[0] && pcM) || (mL2[1] && rgM) || (mL2[2] && dM));
      if (cfgWe && cfgSel == 3'd6) begin
        mSt = (cfgData[5:3] != 0) ? 1 : 0;
      end else if (mSt == 1 && h1) begin
        if (mTwo) mSt = 3;
        else begin mSt = 2; mPulse = 1; mAct = mResp; end
      end else if (mSt == 3 && h2) begin
        mSt = 4; mPulse = 1; mAct = mResp;
      end
      if (cfgWe) begin
        case (cfgSel)
          3'd0: mPcVal  = cfgData[AW-1:0];
          3'd1: mPcMask = cfgData[AW-1:0];
          3'd2: mLo     = cfgData[AW-1:0];
          3'd3: mHi     = cfgData[AW-1:0];
          3'd4: mDv     = cfgData[DW-1:0];
          3'd5: mDm     = cfgData[DW-1:0];
          3'd6: begin
            mResp = int'(cfgData[1:0]); mTwo = cfgData[2];
            mL1 = cfgData[5:3]; mL2 = cfgData[8:6];
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(curReq, int'(trigPulse), int'(mPulse));
      chk("R5", int'(trigAction), mAct);
      chk("R7", int'(statusOut), mSt);
      chk("R9", int'(ddataOut), traceBusy ? int'(traceData) : mSt);
      if (trigPulse) begin
        pulseCnt++;
        lastAct = int'(trigAction);
      end
    end
  end

  task automatic drive(input logic we, input logic [2:0] sel, input logic [CW-1:0] d,
                       input logic v, input logic [AW-1:0] pc, input logic [AW-1:0] oa,
                       input logic [DW-1:0] od);
    @(posedge clk); #1;
    cfgWe = we; cfgSel = sel; cfgData = d;
    busValid = v; pcAddr = pc; opAddr = oa; opData = od;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [CW-1:0] d);
    drive(1'b1, sel, d, 1'b0, '0, '0, '0);
  endtask

  task automatic bus(input logic v, input logic [AW-1:0] pc, input logic [AW-1:0] oa,
                     input logic [DW-1:0] od);
    drive(1'b0, 3'd0, '0, v, pc, oa, od);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bus(1'b0, '0, '0, '0);
  endtask

  function automatic logic [CW-1:0] tdef(input int resp, input bit two,
                                         input bit [2:0] l1, input bit [2:0] l2);
    return CW'({l2, l1, two, resp[1:0]});
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10", int'(statusOut), 0);
    chk("R10", int'(trigPulse), 0);
    rstN = 1'b1;
    idle(2);

    // R1 masked pc compare, R4 qualifier, R11 response field
    curReq = "R1";
    wr(3'd0, 32'h1230); wr(3'd1, 32'hFFF0); wr(3'd6, tdef(2, 0, 3'b001, 3'b000));
    p0 = pulseCnt;
    bus(1'b1, 16'h1334, 0, 0);
    bus(1'b0, 16'h1235, 0, 0);
    idle(2);
    chk("R4", pulseCnt - p0, 0);
    bus(1'b1, 16'h123F, 0, 0);
    idle(2);
    chk("R1", pulseCnt - p0, 1);
    chk("R11", lastAct, 2);
    bus(1'b1, 16'h1230, 0, 0);
    idle(2);
    chk("R7", pulseCnt - p0, 1);
    chk("R7", int'(statusOut), 2);

    // R2 inclusive window
    curReq = "R2";
    wr(3'd2, 32'h0100); wr(3'd3, 32'h01FF); wr(3'd6, tdef(1, 0, 3'b010, 3'b000));
    p0 = pulseCnt;
    bus(1'b1, 0, 16'h00FF, 0); bus(1'b1, 0, 16'h0200, 0);
    idle(2);
    chk("R2", pulseCnt - p0, 0);
    bus(1'b1, 0, 16'h01FF, 0);
    idle(2);
    chk("R2", pulseCnt - p0, 1);
    wr(3'd6, tdef(1, 0, 3'b010, 3'b000));
    bus(1'b1, 0, 16'h0100, 0);
    idle(2);
    chk("R2", pulseCnt - p0, 2);
    wr(3'd2, 32'hFFFF); wr(3'd3, 32'hFFFF); wr(3'd6, tdef(1, 0, 3'b010, 3'b000));
    bus(1'b1, 0, 16'hFFFE, 0);
    idle(2);
    chk("R2", pulseCnt - p0, 2);
    bus(1'b1, 0, 16'hFFFF, 0);
    idle(2);
    chk("R2", pulseCnt - p0, 3);

    // R3 masked data compare
    curReq = "R3";
    wr(3'd4, 32'hAB00); wr(3'd5, 32'hFF00); wr(3'd6, tdef(3, 0, 3'b100, 3'b000));
    p0 = pulseCnt;
    bus(1'b1, 0, 0, 16'hAC00);
    idle(2);
    chk("R3", pulseCnt - p0, 0);
    bus(1'b1, 0, 0, 16'hABCD);
    idle(2);
    chk("R3", pulseCnt - p0, 1);
    chk("R5", lastAct, 3);

    // R5 any enabled level-1 comparator fires
    curReq = "R5";
    wr(3'd6, tdef(1, 0, 3'b011, 3'b000));
    p0 = pulseCnt;
    bus(1'b1, 16'h0000, 16'hFFFF, 0);
    idle(2);
    chk("R5", pulseCnt - p0, 1);

    // R6 two-level sequencing
    curReq = "R6";
    wr(3'd6, tdef(1, 1, 3'b001, 3'b100));
    p0 = pulseCnt;
    bus(1'b1, 16'h0000, 0, 16'hAB11);
    idle(2);
    chk("R6", pulseCnt - p0, 0);
    chk("R6", int'(statusOut), 1);
    bus(1'b1, 16'h1230, 0, 16'h0000);
    idle(2);
    chk("R6", int'(statusOut), 3);
    chk("R6", pulseCnt - p0, 0);
    bus(1'b1, 16'h0000, 0, 16'hABFF);
    idle(2);
    chk("R6", pulseCnt - p0, 1);
    chk("R6", int'(statusOut), 4);
    wr(3'd6, tdef(1, 1, 3'b001, 3'b100));
    bus(1'b1, 16'h1231, 0, 16'hAB00);
    idle(2);
    chk("R6", int'(statusOut), 3);
    chk("R6", pulseCnt - p0, 1);

    // R8 rewrite during a live match
    curReq = "R8";
    p0 = pulseCnt;
    drive(1'b1, 3'd6, tdef(2, 0, 3'b001, 3'b000), 1'b1, 16'h1232, 0, 0);
    idle(2);
    chk("R8", pulseCnt - p0, 0);
    chk("R8", int'(statusOut), 1);
    wr(3'd6, 32'h0);
    bus(1'b1, 16'h1232, 0, 0);
    idle(2);
    chk("R8", int'(statusOut), 0);
    chk("R8", pulseCnt - p0, 0);

    // R9 shared nibble
    @(posedge clk); #1;
    traceBusy = 1'b1; traceData = 4'hA;
    @(negedge clk); #1;
    chk("R9", int'(ddataOut), 10);
    traceBusy = 1'b0;
    #1;
    chk("R9", int'(ddataOut), int'(statusOut));

    // Random mix against the reference model
    curReq = "R7";
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      traceBusy = ($urandom_range(0, 3) == 0);
      traceData = 4'($urandom_range(0, 15));
      cfgWe = ($urandom_range(0, 7) == 0);
      cfgSel = 3'($urandom_range(0, 6));
      cfgData = (cfgSel == 3'd6) ? CW'($urandom_range(0, 511))
                                  : CW'($urandom_range(0, 15));
      busValid = ($urandom_range(0, 3) != 0);
      pcAddr = AW'($urandom_range(0, 15));
      opAddr = AW'($urandom_range(0, 15));
      opData = DW'($urandom_range(0, 15));
    end
    traceBusy = 1'b0;
    idle(3);
    finishRun();
  end
endmodule